// File: doc/BRIEF.md
# Multi-port GPIO register bank

The block holds the configuration and data state for a set of GPIO ports, each with 32 pins, behind a simple 32-bit register interface with separate read and write strobes. Every port has its own window of nine consecutive words. Within that window, packed fields choose each pin's function, hold its output data, set its 2-bit drive code and request a pull resistor. The block turns these fields into per-pin pad controls: output value, output enable, pull-up request, pull-down request, drive code, and a 3-bit function code for a pad multiplexer outside the block. Pad input levels pass through a two-flop synchronizer and can be read back through the data word.

Software changes one pin by reading a whole word, editing that pin's field and writing the word back. Every write replaces every field in the addressed word. A function code of 1 makes a pin a driven output. Code 0 makes it a plain input. Codes 2 to 7 select alternate functions that are only passed on to the pad multiplexer, and the pin's output enable from this block stays low for them. Read responses are sequenced by a two-state bus controller. ST_IDLE moves to ST_RESP when a read is accepted, and so does ST_RESP. ST_RESP returns to ST_IDLE when no read is requested. The response is valid while the controller is in ST_RESP.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads zero. Every pin is then an input with output enable low, no pull, drive code 0 and function code 0.
- R2: Port p's window starts at byte address p*0x24. Byte offsets 0x00, 0x04, 0x08 and 0x0C each hold eight pins. Pin j sits in the word at offset 4*(j/8), in a 4-bit slot at bits 4*(j%8). The low 3 bits of the slot hold the function code and the slot's top bit always reads 0.
- R3: Function code 1 drives output enable high for the pin. Every other code keeps it low. The pin's function code is exported unchanged on pin_func, in bits 3*(32*p+j) and up.
- R4: Reading the data word (offset 0x10) returns the stored data bit for pins with function code 1. For all other pins it returns the pad level. A pad change made just before clock edge E is not yet visible to a read sampled at edge E+1, and is visible to a read sampled at edge E+2.
- R5: The drive words at offsets 0x14 (pins 0–15) and 0x18 (pins 16–31) hold a 2-bit code per pin at bits 2*(j%16). The code appears on pin_drive and reads back unchanged.
- R6: The pull words at offsets 0x1C (pins 0–15) and 0x20 (pins 16–31) hold a 2-bit code per pin at bits 2*(j%16). Code 1 requests pull-up, code 2 requests pull-down, and codes 0 and 3 request neither. All codes read back as written.
- R7: A write replaces every field of the addressed word and leaves all other words of all ports unchanged.
- R8: Reads of addresses beyond the last port window, or with a nonzero low two address bits, return zero. Writes to such addresses change nothing.
- R9: bus_rvalid is high in exactly the cycle after each cycle in which bus_rd was sampled high. It carries that read's data, and back-to-back reads each get their own response.
- R10: The data word stores written bits for every pin regardless of its function. pin_out always shows the stored bit, so switching a pin to output drives the value written earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response valid |
| pad_in | input | NUM_PORTS*32 | Asynchronous pad input levels, port-major |
| pin_out | output | NUM_PORTS*32 | Output value per pin |
| pin_oe | output | NUM_PORTS*32 | Output enable per pin |
| pin_pu | output | NUM_PORTS*32 | Pull-up request per pin |
| pin_pd | output | NUM_PORTS*32 | Pull-down request per pin |
| pin_drive | output | NUM_PORTS*64 | 2-bit drive code per pin |
| pin_func | output | NUM_PORTS*96 | 3-bit function code per pin for the pad multiplexer |

## Verification
A corrupted field register shows up on the pin outputs in the cycle after the write that caused it. It also shows up in any read of that word, one cycle after the read strobe. A decode error that aliases an undefined address onto a port window surfaces as a nonzero read of that address, or as a changed field in a port that was never written. A wrong synchronizer depth shifts by one cycle the edge at which a changed pad level appears in the data word, so two back-to-back reads around that edge expose it. A wrong bus-controller state shows up as a missing, extra or misaligned response on the very next cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int WORD_W        = 32;
    localparam int PINS_PER_PORT = 32;
    localparam int WIN_WORDS     = 9;
    localparam int FN_W          = 3;
    localparam int SLOT_W        = 4;
    localparam int SLOTS_PER_FN  = WORD_W / SLOT_W;
    localparam int F2_W          = 2;
    localparam int F2_PER_WORD   = WORD_W / F2_W;

    typedef enum logic [3:0] {
        W_FN0   = 4'd0,
        W_FN1   = 4'd1,
        W_FN2   = 4'd2,
        W_FN3   = 4'd3,
        W_DATA  = 4'd4,
        W_DRV0  = 4'd5,
        W_DRV1  = 4'd6,
        W_PULL0 = 4'd7,
        W_PULL1 = 4'd8
    } win_word_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

    localparam logic [FN_W-1:0] FN_INPUT  = 3'd0;
    localparam logic [FN_W-1:0] FN_OUTPUT = 3'd1;

    localparam logic [F2_W-1:0] PULL_UP   = 2'd1;
    localparam logic [F2_W-1:0] PULL_DOWN = 2'd2;

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS  = 4,
    parameter int ADDR_W     = 10,
    parameter int PORT_IDX_W = 2
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic                  hit,
    output logic [PORT_IDX_W-1:0] port_idx,
    output win_word_e             word_sel
);
    localparam int WADDR_W = ADDR_W - 2;

    logic [WADDR_W-1:0] waddr;
    logic               aligned;

    assign waddr   = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        hit      = 1'b0;
        port_idx = '0;
        word_sel = W_FN0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (aligned && (int'(waddr) >= p * WIN_WORDS) &&
                (int'(waddr) < (p + 1) * WIN_WORDS)) begin
                hit      = 1'b1;
                port_idx = PORT_IDX_W'(p);
                word_sel = win_word_e'(4'(int'(waddr) - p * WIN_WORDS));
            end
        end
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_bank_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  win_word_e                     word_wr,
    input  logic [WORD_W-1:0]             wdata,
    input  win_word_e                     word_rd,
    input  logic [PINS_PER_PORT-1:0]      pad_level,
    output logic [WORD_W-1:0]             rd_word,
    output logic [PINS_PER_PORT-1:0]      pin_out,
    output logic [PINS_PER_PORT-1:0]      pin_oe,
    output logic [PINS_PER_PORT-1:0]      pin_pu,
    output logic [PINS_PER_PORT-1:0]      pin_pd,
    output logic [PINS_PER_PORT*F2_W-1:0] pin_drive,
    output logic [PINS_PER_PORT*FN_W-1:0] pin_func
);
    localparam int F2_TOTAL = PINS_PER_PORT * F2_W;

    logic [FN_W-1:0]          fn_q [PINS_PER_PORT];
    logic [PINS_PER_PORT-1:0] data_q;
    logic [F2_TOTAL-1:0]      drv_q;
    logic [F2_TOTAL-1:0]      pull_q;
    logic [PINS_PER_PORT-1:0] data_view;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PINS_PER_PORT; i++) fn_q[i] <= FN_INPUT;
            data_q <= '0;
            drv_q  <= '0;
            pull_q <= '0;
        end else if (wr_en) begin
            unique case (word_wr)
                W_FN0, W_FN1, W_FN2, W_FN3: begin
                    for (int s = 0; s < SLOTS_PER_FN; s++) begin
                        fn_q[int'(word_wr[1:0]) * SLOTS_PER_FN + s] <= wdata[s*SLOT_W +: FN_W];
                    end
                end
                W_DATA:  data_q <= wdata;
                W_DRV0:  drv_q[WORD_W-1:0]          <= wdata;
                W_DRV1:  drv_q[F2_TOTAL-1:WORD_W]   <= wdata;
                W_PULL0: pull_q[WORD_W-1:0]         <= wdata;
                W_PULL1: pull_q[F2_TOTAL-1:WORD_W]  <= wdata;
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < PINS_PER_PORT; i++) begin : g_pin
        assign pin_oe[i]                = (fn_q[i] == FN_OUTPUT);
        assign pin_pu[i]                = (pull_q[i*F2_W +: F2_W] == PULL_UP);
        assign pin_pd[i]                = (pull_q[i*F2_W +: F2_W] == PULL_DOWN);
        assign pin_func[i*FN_W +: FN_W] = fn_q[i];
        assign data_view[i]             = pin_oe[i] ? data_q[i] : pad_level[i];
    end

    assign pin_out   = data_q;
    assign pin_drive = drv_q;

    always_comb begin
        rd_word = '0;
        unique case (word_rd)
            W_FN0, W_FN1, W_FN2, W_FN3: begin
                for (int s = 0; s < SLOTS_PER_FN; s++) begin
                    rd_word[s*SLOT_W +: SLOT_W] =
                        {1'b0, fn_q[int'(word_rd[1:0]) * SLOTS_PER_FN + s]};
                end
            end
            W_DATA:  rd_word = data_view;
            W_DRV0:  rd_word = drv_q[WORD_W-1:0];
            W_DRV1:  rd_word = drv_q[F2_TOTAL-1:WORD_W];
            W_PULL0: rd_word = pull_q[WORD_W-1:0];
            W_PULL1: rd_word = pull_q[F2_TOTAL-1:WORD_W];
            default: rd_word = '0;
        endcase
    end

    // Writes to any other word leave the data bits alone (R7)
    assert_data_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word_wr != W_DATA) |=> $stable(data_q));

    // Data bits are captured for every pin regardless of function (R10)
    assert_data_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word_wr == W_DATA) |=> (data_q == $past(wdata)));

    // Writes to the data word leave the drive fields alone (R7)
    assert_drive_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word_wr == W_DATA) |=> $stable(drv_q));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic                            bus_wr,
    input  logic [31:0]                     bus_wdata,
    input  logic                            bus_rd,
    output logic [31:0]                     bus_rdata,
    output logic                            bus_rvalid,
    input  logic [NUM_PORTS*32-1:0]         pad_in,
    output logic [NUM_PORTS*32-1:0]         pin_out,
    output logic [NUM_PORTS*32-1:0]         pin_oe,
    output logic [NUM_PORTS*32-1:0]         pin_pu,
    output logic [NUM_PORTS*32-1:0]         pin_pd,
    output logic [NUM_PORTS*64-1:0]         pin_drive,
    output logic [NUM_PORTS*96-1:0]         pin_func
);
    localparam int PIN_TOTAL  = NUM_PORTS * PINS_PER_PORT;
    localparam int PORT_IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int DRV_SPAN   = PINS_PER_PORT * F2_W;
    localparam int FN_SPAN    = PINS_PER_PORT * FN_W;

    logic [PIN_TOTAL-1:0]  pad_sync;
    logic                  dec_hit;
    logic [PORT_IDX_W-1:0] dec_port;
    win_word_e             dec_word;
    logic [WORD_W-1:0]     port_rd [NUM_PORTS];
    logic [WORD_W-1:0]     rd_sel;
    logic [WORD_W-1:0]     rdata_q;
    bus_state_e            state_q;
    bus_state_e            state_d;

    gpio_pad_sync #(.WIDTH(PIN_TOTAL)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    gpio_addr_decode #(
        .NUM_PORTS  (NUM_PORTS),
        .ADDR_W     (ADDR_W),
        .PORT_IDX_W (PORT_IDX_W)
    ) u_dec (
        .addr     (bus_addr),
        .hit      (dec_hit),
        .port_idx (dec_port),
        .word_sel (dec_word)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic port_wr;
        assign port_wr = bus_wr && dec_hit && (dec_port == PORT_IDX_W'(p));

        gpio_port_regs u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (port_wr),
            .word_wr   (dec_word),
            .wdata     (bus_wdata),
            .word_rd   (dec_word),
            .pad_level (pad_sync[p*PINS_PER_PORT +: PINS_PER_PORT]),
            .rd_word   (port_rd[p]),
            .pin_out   (pin_out[p*PINS_PER_PORT +: PINS_PER_PORT]),
            .pin_oe    (pin_oe[p*PINS_PER_PORT +: PINS_PER_PORT]),
            .pin_pu    (pin_pu[p*PINS_PER_PORT +: PINS_PER_PORT]),
            .pin_pd    (pin_pd[p*PINS_PER_PORT +: PINS_PER_PORT]),
            .pin_drive (pin_drive[p*DRV_SPAN +: DRV_SPAN]),
            .pin_func  (pin_func[p*FN_SPAN +: FN_SPAN])
        );
    end

    always_comb begin
        rd_sel = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (dec_hit && dec_port == PORT_IDX_W'(p)) rd_sel = port_rd[p];
        end
    end

    // Bus controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bus controller: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = bus_rd ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = bus_rd ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Bus controller: outputs
    always_comb begin
        bus_rvalid = (state_q == ST_RESP);
        bus_rdata  = rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_sel;
    end

    // Each accepted read gets a response next cycle (R9)
    assert_resp_follows_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // No response without a read the cycle before (R9)
    assert_no_spurious_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    // Undefined addresses read as zero (R8)
    assert_undef_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !dec_hit) |=> (bus_rdata == '0));
endmodule

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
    localparam int NP     = 4;
    localparam int AW     = 10;
    localparam int NPIN   = NP * 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NPIN-1:0]   pad_in = '0;
    logic [NPIN-1:0]   pin_out, pin_oe, pin_pu, pin_pd;
    logic [NP*64-1:0]  pin_drive;
    logic [NP*96-1:0]  pin_func;

    int checks = 0;
    int failures = 0;
    int responses = 0;
    int requests = 0;
    bit finished = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    gpio_bank #(.NUM_PORTS(NP), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_pd(pin_pd),
        .pin_drive(pin_drive), .pin_func(pin_func)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        requests++;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            responses++;
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R9 unexpected response actual=%h expected=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 64'(bus_rdata), 64'(e));
            end
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] pad0, pad0b;
        pad0  = 32'hA5A5_5A5A;
        pad0b = 32'h0F0F_F0F0;
        pad_in = {32'h0, 32'h0, 32'h0, pad0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 oe", 64'(pin_oe), 64'(0));
        check("R1 pull", 64'(pin_pu | pin_pd), 64'(0));
        check("R1 drive", pin_drive[63:0] | pin_drive[255:192], 64'(0));
        check("R1 func", 64'(|pin_func), 64'(0));
        check("R1 rvalid idle", 64'(bus_rvalid), 64'(0));
        for (int w = 0; w < 9; w++) begin
            if (w != 4) rd(AW'(36 + 4*w), 32'h0, "R1 port1 word");
        end
        drain();

        // R2/R3: function slots, top bit dropped, alternates keep oe low
        wr(10'h024, 32'hFFFF_FFFF);
        check("R3 alt func export", 64'(pin_func[96 +: 24]), 64'hFF_FFFF);
        check("R3 alt oe low", 64'(pin_oe[63:32]), 64'(0));
        wr(10'h030, 32'h1000_0000);
        check("R2 slot of pin 31 port1", 64'(pin_oe[63]), 64'(1));
        check("R3 func code pin31", 64'(pin_func[96+93 +: 3]), 64'(1));
        rd(10'h024, 32'h7777_7777, "R2 slot top bit reads zero");
        rd(10'h030, 32'h1000_0000, "R2 word3 readback");
        drain();

        // R10/R4: data word, input vs output pins
        wr(10'h000, 32'h0000_0011);
        wr(10'h010, 32'h0000_0022);
        check("R3 oe port0", 64'(pin_oe[31:0]), 64'h3);
        check("R10 pin_out holds stored bits", 64'(pin_out[31:0]), 64'h22);
        rd(10'h010, (32'h22 & 32'h3) | (pad0 & ~32'h3), "R4 data mix");
        drain();
        wr(10'h000, 32'h0010_0011);
        check("R10 pin5 now driven", 64'(pin_oe[5]), 64'(1));
        rd(10'h010, (32'h22 & 32'h23) | (pad0 & ~32'h23), "R10 stored bit visible");
        drain();

        // R4: synchronizer latency
        pad_in[31:0] = pad0b;
        @(negedge clk);
        rd(10'h010, (32'h22 & 32'h23) | (pad0 & ~32'h23), "R4 pad not yet visible");
        rd(10'h010, (32'h22 & 32'h23) | (pad0b & ~32'h23), "R4 pad visible");
        drain();

        // R5: drive fields on port2
        wr(10'h05C, 32'h0000_001B);
        wr(10'h060, 32'h4000_0000);
        check("R5 drive port2", pin_drive[128 +: 64], {32'h4000_0000, 32'h0000_001B});
        rd(10'h060, 32'h4000_0000, "R5 drive readback");
        drain();

        // R6: pull codes on port3
        wr(10'h088, 32'h0000_00E4);
        wr(10'h08C, 32'h8000_0000);
        check("R6 pull-up", 64'(pin_pu[127:96]), 64'h2);
        check("R6 pull-down", 64'(pin_pd[127:96]), 64'h8000_0004);
        rd(10'h088, 32'h0000_00E4, "R6 code 3 reads back");
        drain();

        // R7: whole-word replacement
        wr(10'h088, 32'h0000_0001);
        check("R7 pu replaced", 64'(pin_pu[127:96]), 64'h1);
        check("R7 pd other word kept", 64'(pin_pd[127:96]), 64'h8000_0000);
        rd(10'h08C, 32'h8000_0000, "R7 neighbour word kept");
        drain();

        // R8: undefined and misaligned addresses
        wr(10'h090, 32'hFFFF_FFFF);
        wr(10'h002, 32'h0000_0000);
        wr(10'h3FC, 32'hFFFF_FFFF);
        rd(10'h090, 32'h0, "R8 past last window");
        rd(10'h3FC, 32'h0, "R8 top of space");
        rd(10'h012, 32'h0, "R8 misaligned read");
        rd(10'h000, 32'h0010_0011, "R8 port0 unchanged");
        drain();
        check("R8 oe unchanged", 64'(pin_oe[63:0]), {32'h8000_0000, 32'h0000_0023});

        // R9: back-to-back reads
        rd(10'h024, 32'h7777_7777, "R9 b2b first");
        rd(10'h060, 32'h4000_0000, "R9 b2b second");
        rd(10'h088, 32'h0000_0001, "R9 b2b third");
        drain();
        check("R9 one response per read", 64'(responses), 64'(requests));
        check("R9 rvalid idle", 64'(bus_rvalid), 64'(0));

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule